// File: doc/BRIEF.md
# Debug Exception Control Unit

This unit keeps the debug-mode control state of a processor core. It holds a 32-bit debug status word and a debug return-PC register. When the core asks to enter a debug exception, the unit does several things at one clock edge. It rewrites the status word, stores the PC of the faulting instruction, and raises a one-cycle redirect pulse. The pulse carries the fixed debug vector as the new fetch target. The core uses the same pulse to drop its compressed-instruction mode and its pending-interrupt flag.

Two sources can start an entry. The first is an external request that carries a one-hot cause. The second is the software breakpoint instruction, which the unit decodes itself from the instruction word. A breakpoint reached while the core is already in debug mode is a nested exception. It sets no cause bit. Instead it records an exception code in a 4-bit field of the status word. Software can read the status word at any time. A software write changes only a fixed set of writable bits.

Top module: `dbg_exc_ctrl`

## Requirements
- R1: After a synchronous reset, `dbg_rdata_o` reads 0x00010000, `depc_o` reads 0 and `redirect_o` is low.
- R2: An accepted entry request drives `redirect_o` high for exactly the one cycle after the request edge. `redirect_pc_o` is always 0xBFC00480, sign-extended to VEC_W bits.
- R3: On entry, `depc_o` takes the value of `cur_pc_i` sampled at the request edge.
- R4: On entry, status bit 30 (debug mode) and bit 20 (imprecise-error inhibit) become 1. Bit 31 becomes the value of `cur_in_slot_i`.
- R5: When debug mode is not active, an external request (`exc_req_i`) clears the eight cause bits {19,18,5,4,3,2,1,0}. It then sets only the bit selected by the one-hot `exc_cause_i`. Index 0..5 map to bits 0..5, index 6 maps to bit 18 and index 7 maps to bit 19. Bits 13:10 and all other bits except 31, 30 and 20 keep their value.
- R6: When debug mode is already active, an external request clears all eight cause bits and sets none.
- R7: The software breakpoint is recognised only when `insn_valid_i` is 1, `insn_i[31:26]` is 6'b011100 and `insn_i[5:0]` is 6'h3F. Bits 25:6 are ignored. Any other word starts no entry.
- R8: A software breakpoint outside debug mode clears bits 13:10 and the eight cause bits, then sets only bit 1.
- R9: A software breakpoint inside debug mode clears the eight cause bits and sets none. It writes the code BKPT_CODE (default 9) into bits 13:10.
- R10: When a software breakpoint and an external request arrive in the same cycle, the breakpoint wins. Only bit 1 is set, and the external cause is discarded.
- R11: A write with `dbg_wr_i`=1 and `dbg_sel_i`=0 replaces only the bits in mask 0x10700180 (bits 28, 22, 21, 20, 8 and 7). All other bits keep their value.
- R12: A write with a nonzero `dbg_sel_i` changes nothing.
- R13: A write in the same cycle as an accepted entry request is dropped, and the entry update applies alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req_i | input | 1 | External debug exception request |
| exc_cause_i | input | 8 | One-hot cause index of the external request |
| insn_valid_i | input | 1 | `insn_i` holds an instruction being executed |
| insn_i | input | 32 | Instruction word checked for the software breakpoint |
| cur_pc_i | input | PC_W | PC of the instruction raising the exception |
| cur_in_slot_i | input | 1 | That instruction sits in a branch delay slot |
| dbg_wr_i | input | 1 | Software write strobe for the status word |
| dbg_sel_i | input | 3 | Register select of the write; only 0 is implemented |
| dbg_wdata_i | input | 32 | Write data |
| dbg_rdata_o | output | 32 | Current status word |
| depc_o | output | PC_W | Debug return PC |
| redirect_o | output | 1 | One-cycle pulse: fetch from `redirect_pc_o`, clear compressed mode and pending interrupt |
| redirect_pc_o | output | VEC_W | Debug vector address |

## Verification
The bench builds the unit with VEC_W=64 and PC_W=32. With VEC_W=64, the sign-extension path of the vector is exercised and its upper 32 bits become visible. The bench sweeps all eight cause indices against both delay-slot values. Each case starts from a status word with every writable bit already set. Nested external and breakpoint entries follow each case, so every cause-to-bit mapping is seen both inside and outside debug mode. Write sweeps cover all eight select values under four data patterns. Near-miss instruction words then probe each field of the breakpoint decode.

// File: rtl/dbgx_pkg.sv
// Package: shared constants and helpers of the debug exception control unit.
// Assumes a 32-bit status word; bit positions here are decoded by the core.
package dbgx_pkg;

    localparam int unsigned STAT_W     = 32;
    localparam int unsigned NUM_CAUSE  = 8;

    localparam int unsigned BIT_SLOT   = 31;
    localparam int unsigned BIT_DMODE  = 30;
    localparam int unsigned BIT_INHIB  = 20;
    localparam int unsigned CODE_LO    = 10;
    localparam int unsigned CODE_HI    = 13;
    localparam int unsigned BIT_BKPT   = 1;

    localparam logic [STAT_W-1:0] RESET_VAL  = 32'h0001_0000;
    localparam logic [STAT_W-1:0] WR_MASK    = 32'h1070_0180;
    localparam logic [STAT_W-1:0] CAUSE_MASK = 32'h000C_003F;
    localparam logic [31:0]       VEC_ADDR   = 32'hBFC0_0480;

    localparam logic [5:0] OPC_SPECIAL2 = 6'b011100;
    localparam logic [5:0] FN_SWBKPT    = 6'h3F;

    // Map a cause index to its bit position in the status word.
    function automatic int unsigned cause_pos(input int unsigned idx);
        return (idx < 6) ? idx : idx + 12;
    endfunction

    // Spread an index-ordered one-hot cause vector onto status bit positions.
    function automatic logic [STAT_W-1:0] cause_spread(input logic [NUM_CAUSE-1:0] oh);
        logic [STAT_W-1:0] r;
        r = '0;
        for (int unsigned i = 0; i < NUM_CAUSE; i++) begin
            r[cause_pos(i)] = oh[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/dbgx_insn_decode.sv
// Module: recognises the software debug breakpoint instruction.
// Assumes a 32-bit instruction word with a major opcode in [31:26] and a
// function field in [5:0]; the remaining bits do not affect the match.
module dbgx_insn_decode
    import dbgx_pkg::*;
(
    input  logic        insn_valid_i,
    input  logic [31:0] insn_i,
    output logic        is_swbkpt_o
);

    logic unused_mid;

    // Match opcode and function fields of a valid instruction.
    always_comb begin
        is_swbkpt_o = insn_valid_i
                    && (insn_i[31:26] == OPC_SPECIAL2)
                    && (insn_i[5:0]   == FN_SWBKPT);
    end

    assign unused_mid = ^insn_i[25:6];

endmodule

// File: rtl/dbgx_entry_calc.sv
// Module: computes the status word that results from a debug exception entry.
// Assumes at most one cause bit is set in cause_oh_i; ignored when the core
// is already in debug mode.
module dbgx_entry_calc
    import dbgx_pkg::*;
#(
    parameter logic [3:0] BKPT_CODE = 4'd9
)(
    input  logic [STAT_W-1:0]    cur_i,
    input  logic [NUM_CAUSE-1:0] cause_oh_i,
    input  logic                 swbkpt_i,
    input  logic                 in_slot_i,
    output logic [STAT_W-1:0]    next_o
);

    logic              was_dm;
    logic [STAT_W-1:0] base;
    logic [STAT_W-1:0] cause_bits;

    // Pick up whether debug mode was already active and spread the cause.
    always_comb begin
        was_dm     = cur_i[BIT_DMODE];
        cause_bits = cause_spread(cause_oh_i);
    end

    // Clear the nested code on a breakpoint, then all causes, then rebuild.
    always_comb begin
        base = cur_i;
        if (swbkpt_i) begin
            base[CODE_HI:CODE_LO] = '0;
        end
        next_o = base & ~CAUSE_MASK;
        if (!was_dm) begin
            next_o = next_o | (cause_bits & CAUSE_MASK);
        end else if (swbkpt_i) begin
            next_o[CODE_HI:CODE_LO] = BKPT_CODE;
        end
        next_o[BIT_SLOT]  = in_slot_i;
        next_o[BIT_DMODE] = 1'b1;
        next_o[BIT_INHIB] = 1'b1;
    end

    // A cause bit survives only outside debug mode, and never more than one.
    always_comb begin
        a_r6_at_most_one_cause: assert ($countones(next_o & CAUSE_MASK) <= 1);
    end

endmodule

// File: rtl/dbgx_vector_gen.sv
// Module: produces the debug vector address at the configured width.
// Assumes VEC_W is at least 32; wider forms are sign-extended from bit 31.
module dbgx_vector_gen
    import dbgx_pkg::*;
#(
    parameter int unsigned VEC_W = 32
)(
    output logic [VEC_W-1:0] vec_o
);

    generate
        if (VEC_W > 32) begin : g_wide
            localparam int unsigned EXT_W = VEC_W - 32;
            // Replicate the top address bit into the upper part.
            assign vec_o = {{EXT_W{VEC_ADDR[31]}}, VEC_ADDR};
        end else begin : g_narrow
            // Native 32-bit vector.
            assign vec_o = VEC_ADDR[VEC_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/dbg_exc_ctrl.sv
// Module: top of the debug exception control unit. Arbitrates between the
// software breakpoint and external debug requests, holds the status word and
// return PC, applies masked software writes, and emits the redirect pulse.
// Assumes inputs are synchronous to clk and exc_cause_i is one-hot when used.
module dbg_exc_ctrl
    import dbgx_pkg::*;
#(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned VEC_W     = 32,
    parameter logic [3:0]  BKPT_CODE = 4'd9
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exc_req_i,
    input  logic [NUM_CAUSE-1:0] exc_cause_i,
    input  logic                 insn_valid_i,
    input  logic [31:0]          insn_i,
    input  logic [PC_W-1:0]      cur_pc_i,
    input  logic                 cur_in_slot_i,
    input  logic                 dbg_wr_i,
    input  logic [2:0]           dbg_sel_i,
    input  logic [31:0]          dbg_wdata_i,
    output logic [31:0]          dbg_rdata_o,
    output logic [PC_W-1:0]      depc_o,
    output logic                 redirect_o,
    output logic [VEC_W-1:0]     redirect_pc_o
);

    localparam logic [NUM_CAUSE-1:0] BKPT_OH = NUM_CAUSE'(1) << BIT_BKPT;

    logic [STAT_W-1:0]    stat_q;
    logic [STAT_W-1:0]    stat_entry;
    logic [PC_W-1:0]      depc_q;
    logic                 redir_q;
    logic                 is_swbkpt;
    logic                 take_ext;
    logic                 entry;
    logic [NUM_CAUSE-1:0] sel_cause;
    logic                 sw_write;

    dbgx_insn_decode u_dec (
        .insn_valid_i (insn_valid_i),
        .insn_i       (insn_i),
        .is_swbkpt_o  (is_swbkpt)
    );

    // Breakpoint outranks the external request; writes yield to both.
    always_comb begin
        take_ext  = exc_req_i && !is_swbkpt;
        entry     = is_swbkpt || exc_req_i;
        sel_cause = is_swbkpt ? BKPT_OH : exc_cause_i;
        sw_write  = dbg_wr_i && (dbg_sel_i == 3'd0) && !entry;
    end

    dbgx_entry_calc #(.BKPT_CODE(BKPT_CODE)) u_calc (
        .cur_i      (stat_q),
        .cause_oh_i (sel_cause),
        .swbkpt_i   (is_swbkpt),
        .in_slot_i  (cur_in_slot_i),
        .next_o     (stat_entry)
    );

    dbgx_vector_gen #(.VEC_W(VEC_W)) u_vec (
        .vec_o (redirect_pc_o)
    );

    // Status word: entry update, masked write, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= RESET_VAL;
        end else if (entry) begin
            stat_q <= stat_entry;
        end else if (sw_write) begin
            stat_q <= (stat_q & ~WR_MASK) | (dbg_wdata_i & WR_MASK);
        end
    end

    // Return PC captured on every entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depc_q <= '0;
        end else if (entry) begin
            depc_q <= cur_pc_i;
        end
    end

    // One-cycle redirect pulse following each entry edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_q <= 1'b0;
        end else begin
            redir_q <= entry;
        end
    end

    assign dbg_rdata_o = stat_q;
    assign depc_o      = depc_q;
    assign redirect_o  = redir_q;

    a_r2_redirect_follows: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> redirect_o);
    a_r2_no_spurious_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        !entry |=> !redirect_o);
    a_r3_depc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> depc_o == $past(cur_pc_i));
    a_r4_mode_bits: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> (dbg_rdata_o[BIT_DMODE] && dbg_rdata_o[BIT_INHIB]
                   && dbg_rdata_o[BIT_SLOT] == $past(cur_in_slot_i)));
    a_r6_nested_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (entry && dbg_rdata_o[BIT_DMODE]) |=> (dbg_rdata_o & CAUSE_MASK) == '0);
    a_r10_bkpt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (take_ext == 1'b0 && exc_req_i && !dbg_rdata_o[BIT_DMODE])
        |=> (dbg_rdata_o & CAUSE_MASK) == (STAT_W'(1) << BIT_BKPT));
    a_r11_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !entry |=> (dbg_rdata_o & ~WR_MASK) == ($past(dbg_rdata_o) & ~WR_MASK));
    a_r12_bad_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!entry && dbg_wr_i && dbg_sel_i != 3'd0) |=> $stable(dbg_rdata_o));
    a_r5_cause_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_i |-> $onehot(exc_cause_i));

endmodule

// File: tb/dbg_exc_ctrl_tb.sv
module dbg_exc_ctrl_tb;

    localparam int unsigned PC_W  = 32;
    localparam int unsigned VEC_W = 64;
    localparam logic [31:0] CMASK = 32'h000C_003F;
    localparam logic [31:0] WMASK = 32'h1070_0180;
    localparam logic [31:0] SWBK  = 32'h7000_003F;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             exc_req_i = 1'b0;
    logic [7:0]       exc_cause_i = '0;
    logic             insn_valid_i = 1'b0;
    logic [31:0]      insn_i = '0;
    logic [PC_W-1:0]  cur_pc_i = '0;
    logic             cur_in_slot_i = 1'b0;
    logic             dbg_wr_i = 1'b0;
    logic [2:0]       dbg_sel_i = '0;
    logic [31:0]      dbg_wdata_i = '0;
    logic [31:0]      dbg_rdata_o;
    logic [PC_W-1:0]  depc_o;
    logic             redirect_o;
    logic [VEC_W-1:0] redirect_pc_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [31:0] exp_dbg;
    logic [31:0] exp_depc;

    always #2.5 clk = ~clk;

    dbg_exc_ctrl #(.PC_W(PC_W), .VEC_W(VEC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req_i), .exc_cause_i(exc_cause_i),
        .insn_valid_i(insn_valid_i), .insn_i(insn_i), .cur_pc_i(cur_pc_i),
        .cur_in_slot_i(cur_in_slot_i), .dbg_wr_i(dbg_wr_i), .dbg_sel_i(dbg_sel_i),
        .dbg_wdata_i(dbg_wdata_i), .dbg_rdata_o(dbg_rdata_o), .depc_o(depc_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int unsigned pos(input int unsigned idx);
        return (idx < 6) ? idx : idx + 12;
    endfunction

    function automatic logic [31:0] mdl_ext(input logic [31:0] o, input int unsigned idx, input logic s);
        logic [31:0] n;
        n = o & ~CMASK;
        if (!o[30]) n[pos(idx)] = 1'b1;
        n[31] = s; n[30] = 1'b1; n[20] = 1'b1;
        return n;
    endfunction

    function automatic logic [31:0] mdl_bk(input logic [31:0] o, input logic s);
        logic [31:0] n;
        n = o & ~CMASK;
        n[13:10] = 4'd0;
        if (!o[30]) n[1] = 1'b1;
        else n[13:10] = 4'd9;
        n[31] = s; n[30] = 1'b1; n[20] = 1'b1;
        return n;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        exc_req_i = 0; exc_cause_i = '0; insn_valid_i = 0; insn_i = '0;
        dbg_wr_i = 0; dbg_sel_i = '0; dbg_wdata_i = '0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        step();
        rst_n = 1;
        exp_dbg = 32'h0001_0000;
        exp_depc = '0;
    endtask

    task automatic do_write(input logic [2:0] sel, input logic [31:0] d);
        dbg_wr_i = 1; dbg_sel_i = sel; dbg_wdata_i = d;
        step();
        if (sel == 0) exp_dbg = (exp_dbg & ~WMASK) | (d & WMASK);
    endtask

    task automatic do_ext(input int unsigned idx, input logic s, input logic [31:0] pc, input string req);
        exc_req_i = 1; exc_cause_i = 8'(1) << idx; cur_in_slot_i = s; cur_pc_i = pc;
        step();
        exp_dbg = mdl_ext(exp_dbg, idx, s);
        exp_depc = pc;
        chk(req, dbg_rdata_o, exp_dbg);
        chk("R3 depc", depc_o, exp_depc);
        chk("R2 redirect", redirect_o, 1'b1);
    endtask

    task automatic do_bk(input logic s, input logic [31:0] pc, input logic [31:0] w, input string req);
        insn_valid_i = 1; insn_i = w; cur_in_slot_i = s; cur_pc_i = pc;
        step();
        exp_dbg = mdl_bk(exp_dbg, s);
        exp_depc = pc;
        chk(req, dbg_rdata_o, exp_dbg);
        chk("R3 depc", depc_o, exp_depc);
        chk("R2 redirect", redirect_o, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 reset status", dbg_rdata_o, 32'h0001_0000);
        chk("R1 reset depc", depc_o, 0);
        chk("R1 reset redirect", redirect_o, 0);
        chk("R2 vector", redirect_pc_o, 64'hFFFF_FFFF_BFC0_0480);

        // Cause sweep outside and inside debug mode, both slot values.
        for (int idx = 0; idx < 8; idx++) begin
            for (int s = 0; s < 2; s++) begin
                do_reset();
                do_write(3'd0, 32'hFFFF_FFFF);
                chk("R11 preset", dbg_rdata_o, exp_dbg);
                do_ext(idx, s[0], 32'h8000_1000 + idx * 16 + s, "R5 R4 first entry");
                step();
                chk("R2 pulse ends", redirect_o, 0);
                do_ext((idx + 3) % 8, !s[0], 32'h9000_0000 + idx, "R6 nested external");
                do_bk(s[0], 32'hA000_0000 + idx, SWBK, "R9 nested breakpoint");
                do_ext(idx, s[0], 32'hB000_0000 + idx, "R5 R6 code kept on external");
            end
        end

        // Breakpoint outside debug mode.
        do_reset();
        do_bk(1'b1, 32'h1234_5678, SWBK | 32'h03FF_FFC0, "R8 R7 breakpoint outside mode");

        // Priority of breakpoint over external request.
        do_reset();
        exc_req_i = 1; exc_cause_i = 8'h20;
        do_bk(1'b0, 32'h0000_0040, SWBK, "R10 breakpoint wins");
        chk("R10 no interrupt cause", dbg_rdata_o[5], 1'b0);

        // Write dropped during entry.
        do_reset();
        dbg_wr_i = 1; dbg_sel_i = 0; dbg_wdata_i = 32'hFFFF_FFFF;
        do_ext(2, 1'b0, 32'h0000_0100, "R13 write dropped");

        // Write sweep over selects and patterns.
        for (int sel = 0; sel < 8; sel++) begin
            for (int p = 0; p < 4; p++) begin
                logic [31:0] d;
                d = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 :
                    (p == 2) ? 32'hA5A5_A5A5 : 32'h5A5A_5A5A;
                do_write(3'(sel), d);
                if (sel == 0) chk("R11 masked write", dbg_rdata_o, exp_dbg);
                else          chk("R12 bad select ignored", dbg_rdata_o, exp_dbg);
                chk("R11 no redirect", redirect_o, 0);
            end
        end

        // Near-miss instruction words.
        do_reset();
        for (int k = 0; k < 4; k++) begin
            insn_valid_i = (k != 3);
            insn_i = (k == 0) ? 32'h7000_003E : (k == 1) ? 32'h7400_003F :
                     (k == 2) ? 32'h0000_003F : SWBK;
            step();
            chk("R7 no decode redirect", redirect_o, 0);
            chk("R7 status unchanged", dbg_rdata_o, exp_dbg);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule